// File: doc/BRIEF.md
# UART Interrupt Status and Vector Unit

This block gathers the interrupt causes of a single-channel UART into one 8-bit status word. It combines that word with a software-written enable mask to drive one active-low interrupt request line. Three causes are sticky and each has its own clearing rule. The first is an input-pin change, cleared as a side effect of the CPU reading the pin-change register. The second is a counter/timer event, cleared by a stop command that leaves a running timer alone. The third is a break transition, cleared only by an explicit command. The two FIFO-level causes are not latched: they track their source lines.

The block also holds a one-byte vector. The vector is returned during an interrupt acknowledge cycle, and it is also returned by an ordinary read of its own address. The CPU port shares one address between the status word (reads) and the mask (writes). The mask only gates the request line: a status read always shows the true, unmasked causes.

Top module: `uart_irq_unit`

## Requirements
- R1: `irq_n` is registered. In each cycle it equals the inverse of the OR-reduction of (status AND mask) as those values stood one clock earlier. A status or mask change therefore reaches `irq_n` one clock later.
- R2: A read of address 0x5 returns the full status word whatever the mask holds. Status bits 6, 5 and 4 always read 0.
- R3: A `ev_port_change` pulse sets status bit 7. A `clr_port_read` pulse clears it. When both arrive in the same cycle, the bit ends set.
- R4: With `timer_mode` at 0, an `ev_count_tc` pulse sets status bit 3 and a `cmd_stop_count` pulse clears it; set wins over clear. In this mode `ev_timer_zero` has no effect.
- R5: With `timer_mode` at 1, status bit 3 sets on every second `ev_timer_zero` pulse, counted from the cycle `timer_mode` went high. `cmd_stop_count` clears the bit but does not restart that pairing.
- R6: A `ev_break_edge` pulse sets status bit 2. Only `cmd_reset_break` clears it, and set wins over clear. `clr_port_read` and `cmd_stop_count` leave it unchanged.
- R7: Status bit 1 follows `rx_level_irq` and status bit 0 follows `tx_level_irq`, each one clock later.
- R8: After reset the status word reads 0x00, the mask is 0x00, the vector is 0x0F and `irq_n` is 1.
- R9: While `iack_n` is 0, `cpu_rdata` carries the vector whatever the address or read strobe. A read of address 0xC also returns it, and a write to 0xC loads it.
- R10: A write to address 0x5 loads the mask, which is never read back: a read of 0x5 gives status. Writes to any other address change neither mask, vector nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, acts on the rising clock edge |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational; 0 when idle |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| ev_port_change | input | 1 | Enabled input-pin change pulse |
| ev_count_tc | input | 1 | Counter terminal count pulse |
| ev_timer_zero | input | 1 | Timer reached zero pulse |
| timer_mode | input | 1 | 1 = timer mode, 0 = counter mode |
| ev_break_edge | input | 1 | Break start or end pulse |
| rx_level_irq | input | 1 | Receive FIFO level condition |
| tx_level_irq | input | 1 | Transmit FIFO level condition |
| clr_port_read | input | 1 | Pin-change register read pulse |
| cmd_stop_count | input | 1 | Stop-counter command pulse |
| cmd_reset_break | input | 1 | Reset-break-change command pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that event, clear and command inputs are single-cycle pulses sampled on the rising edge. They also assume that `timer_mode` changes only between pulses, so that the pairing of timer zero events is well defined. The stimulus drives every input on the falling edge and drops each pulse after one cycle. It changes `timer_mode` only in rows that carry no `ev_timer_zero` pulse of the opposite mode. It holds `iack_n` high except during the explicit acknowledge check.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned BIT_PORT = 7;
  localparam int unsigned BIT_CNT  = 3;
  localparam int unsigned BIT_BRK  = 2;
  localparam int unsigned BIT_RX   = 1;
  localparam int unsigned BIT_TX   = 0;
  localparam int unsigned N_STICKY = 3;
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;  // a set in the same cycle wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_port_change,
  input  logic              ev_count_tc,
  input  logic              ev_timer_zero,
  input  logic              timer_mode,
  input  logic              ev_break_edge,
  input  logic              rx_level_irq,
  input  logic              tx_level_irq,
  input  logic              clr_port_read,
  input  logic              cmd_stop_count,
  input  logic              cmd_reset_break,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned IDX_PORT = 2;
  localparam int unsigned IDX_CNT  = 1;
  localparam int unsigned IDX_BRK  = 0;

  logic [N_STICKY-1:0] set_v, clr_v, q_v;
  logic                phase_q, phase_d;
  logic                cnt_set;
  logic [1:0]          lvl_q, lvl_d;

  // timer mode: every second zero count completes one square-wave period
  always_comb begin
    phase_d = phase_q;
    if (!timer_mode)        phase_d = 1'b0;
    else if (ev_timer_zero) phase_d = ~phase_q;
  end

  always_comb begin
    cnt_set = timer_mode ? (ev_timer_zero & phase_q) : ev_count_tc;
    set_v[IDX_PORT] = ev_port_change;
    clr_v[IDX_PORT] = clr_port_read;
    set_v[IDX_CNT]  = cnt_set;
    clr_v[IDX_CNT]  = cmd_stop_count;
    set_v[IDX_BRK]  = ev_break_edge;
    clr_v[IDX_BRK]  = cmd_reset_break;
    lvl_d           = {rx_level_irq, tx_level_irq};
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    uart_irq_sticky u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lvl_q   <= 2'b00;
    end else begin
      phase_q <= phase_d;
      lvl_q   <= lvl_d;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[BIT_PORT] = q_v[IDX_PORT];
    status_o[BIT_CNT]  = q_v[IDX_CNT];
    status_o[BIT_BRK]  = q_v[IDX_BRK];
    status_o[BIT_RX]   = lvl_q[1];
    status_o[BIT_TX]   = lvl_q[0];
  end
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_n_o
);
  logic [STAT_W-1:0] mask_d;
  logic              irq_n_d;

  always_comb begin
    mask_d  = mask_we ? mask_wdata : mask_o;
    irq_n_d = ~(|(status_i & mask_o));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o  <= '0;
      irq_n_o <= 1'b1;
    end else begin
      mask_o  <= mask_d;
      irq_n_o <= irq_n_d;
    end
  end
endmodule

// File: rtl/uart_irq_vector.sv
module uart_irq_vector
  import uart_irq_pkg::*;
#(
  parameter logic [STAT_W-1:0] RESET_VAL = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] vec_o
);
  logic [STAT_W-1:0] vec_d;

  always_comb vec_d = we ? wdata : vec_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_o <= RESET_VAL;
    else        vec_o <= vec_d;
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h5,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 4'hC,
  parameter logic [STAT_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [STAT_W-1:0] cpu_wdata,
  output logic [STAT_W-1:0] cpu_rdata,
  input  logic              iack_n,
  input  logic              ev_port_change,
  input  logic              ev_count_tc,
  input  logic              ev_timer_zero,
  input  logic              timer_mode,
  input  logic              ev_break_edge,
  input  logic              rx_level_irq,
  input  logic              tx_level_irq,
  input  logic              clr_port_read,
  input  logic              cmd_stop_count,
  input  logic              cmd_reset_break,
  output logic              irq_n
);
  logic [STAT_W-1:0] stat_w, mask_w, vec_w;
  logic              mask_we, vec_we;

  always_comb begin
    mask_we = cpu_wr && (cpu_addr == STAT_ADDR);
    vec_we  = cpu_wr && (cpu_addr == VEC_ADDR);
  end

  uart_irq_status u_status (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_port_change  (ev_port_change),
    .ev_count_tc     (ev_count_tc),
    .ev_timer_zero   (ev_timer_zero),
    .timer_mode      (timer_mode),
    .ev_break_edge   (ev_break_edge),
    .rx_level_irq    (rx_level_irq),
    .tx_level_irq    (tx_level_irq),
    .clr_port_read   (clr_port_read),
    .cmd_stop_count  (cmd_stop_count),
    .cmd_reset_break (cmd_reset_break),
    .status_o        (stat_w)
  );

  uart_irq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (cpu_wdata),
    .status_i   (stat_w),
    .mask_o     (mask_w),
    .irq_n_o    (irq_n)
  );

  uart_irq_vector #(.RESET_VAL(VEC_RESET)) u_vector (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (vec_we),
    .wdata (cpu_wdata),
    .vec_o (vec_w)
  );

  // acknowledge takes priority over any ordinary read
  always_comb begin
    cpu_rdata = '0;
    if (!iack_n) begin
      cpu_rdata = vec_w;
    end else if (cpu_rd) begin
      if (cpu_addr == STAT_ADDR)     cpu_rdata = stat_w;
      else if (cpu_addr == VEC_ADDR) cpu_rdata = vec_w;
    end
  end
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iack_n,
  input logic [7:0] cpu_rdata,
  input logic       irq_n,
  input logic       ev_port_change,
  input logic       ev_break_edge,
  input logic       cmd_stop_count,
  input logic       cmd_reset_break,
  input logic       rx_level_irq,
  input logic       tx_level_irq,
  input logic [7:0] stat,
  input logic [7:0] mask,
  input logic [7:0] vec
);
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~(|($past(stat & mask)))); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat[6:4] == 3'b000); // R2
  AST_PORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_port_change |=> stat[7]); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[3] && !cmd_stop_count) |=> stat[3]); // R4
  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break_edge |=> stat[2]); // R6
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && !cmd_reset_break) |=> stat[2]); // R6
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat[1:0] == $past({rx_level_irq, tx_level_irq})); // R7
  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_n |-> cpu_rdata == vec); // R9
endmodule

bind uart_irq_unit uart_irq_unit_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .iack_n          (iack_n),
  .cpu_rdata       (cpu_rdata),
  .irq_n           (irq_n),
  .ev_port_change  (ev_port_change),
  .ev_break_edge   (ev_break_edge),
  .cmd_stop_count  (cmd_stop_count),
  .cmd_reset_break (cmd_reset_break),
  .rx_level_irq    (rx_level_irq),
  .tx_level_irq    (tx_level_irq),
  .stat            (stat_w),
  .mask            (mask_w),
  .vec             (vec_w)
);

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;
  localparam int PERIOD = 10;
  localparam int NROW   = 22;
  // row: {port, tc, tzero, tmode, brk, rx, tx, clr_port, stop, rst_brk, expected status}
  localparam logic [17:0] TBL [NROW] = '{
    {10'b1000000000, 8'h80}, {10'b0000000100, 8'h00},
    {10'b1000000100, 8'h80}, {10'b0000000100, 8'h00},
    {10'b0100000000, 8'h08}, {10'b0000000010, 8'h00},
    {10'b0010000000, 8'h00}, {10'b0011000000, 8'h00},
    {10'b0011000000, 8'h08}, {10'b0001000010, 8'h00},
    {10'b0011000000, 8'h00}, {10'b0001000010, 8'h00},
    {10'b0011000000, 8'h08}, {10'b0000000010, 8'h00},
    {10'b0000100000, 8'h04}, {10'b0000000110, 8'h04},
    {10'b0000000001, 8'h00}, {10'b0000100001, 8'h04},
    {10'b0000000001, 8'h00}, {10'b0000010000, 8'h02},
    {10'b0000011000, 8'h03}, {10'b0000000000, 8'h00}
  };
  localparam string TAG [NROW] = '{
    "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R5", "R5", "R5", "R5",
    "R5", "R5", "R4", "R6", "R6", "R6", "R6", "R6", "R7", "R7", "R7"
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_rd, cpu_wr, iack_n;
  logic [3:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       ev_port_change, ev_count_tc, ev_timer_zero, timer_mode, ev_break_edge;
  logic       rx_level_irq, tx_level_irq, clr_port_read, cmd_stop_count, cmd_reset_break;
  logic       irq_n;
  int         total = 0;
  int         bad = 0;

  always #(PERIOD / 2) clk = ~clk;

  uart_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .iack_n(iack_n),
    .ev_port_change(ev_port_change), .ev_count_tc(ev_count_tc),
    .ev_timer_zero(ev_timer_zero), .timer_mode(timer_mode),
    .ev_break_edge(ev_break_edge), .rx_level_irq(rx_level_irq),
    .tx_level_irq(tx_level_irq), .clr_port_read(clr_port_read),
    .cmd_stop_count(cmd_stop_count), .cmd_reset_break(cmd_reset_break), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    cpu_rd = 1'b1; cpu_addr = a;
    #1 d = cpu_rdata;
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drop_pulses();
    ev_port_change = 0; ev_count_tc = 0; ev_timer_zero = 0; ev_break_edge = 0;
    clr_port_read = 0; cmd_stop_count = 0; cmd_reset_break = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0; iack_n = 1;
    timer_mode = 0; rx_level_irq = 0; tx_level_irq = 0;
    drop_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd(4'h5, d); chk("R8 status", d, 8'h00);
    rd(4'hC, d); chk("R8 vector", d, 8'h0F);
    chk("R8 irq_n", {7'd0, irq_n}, 8'h01);
    iack_n = 0; #1 chk("R9 ack vector", cpu_rdata, 8'h0F); iack_n = 1;

    // table of event rows
    for (int i = 0; i < NROW; i++) begin
      {ev_port_change, ev_count_tc, ev_timer_zero, timer_mode, ev_break_edge,
       rx_level_irq, tx_level_irq, clr_port_read, cmd_stop_count, cmd_reset_break} = TBL[i][17:8];
      step();
      drop_pulses();
      rd(4'h5, d);
      chk(TAG[i], d, TBL[i][7:0]);
    end

    // R10 mask write is not readable; R1 latency
    wr(4'h5, 8'h82);
    rd(4'h5, d); chk("R10 read gives status", d, 8'h00);
    chk("R1 idle irq_n", {7'd0, irq_n}, 8'h01);
    ev_port_change = 1; step(); ev_port_change = 0;
    chk("R1 one-cycle delay", {7'd0, irq_n}, 8'h01);
    step();
    chk("R1 asserted", {7'd0, irq_n}, 8'h00);
    wr(4'h5, 8'h00);
    chk("R1 mask off delay", {7'd0, irq_n}, 8'h00);
    step();
    chk("R1 released", {7'd0, irq_n}, 8'h01);
    rd(4'h5, d); chk("R2 unmasked readback", d, 8'h80);
    wr(4'h3, 8'hFF); step();
    chk("R10 stray write mask", {7'd0, irq_n}, 8'h01);
    rd(4'hC, d); chk("R10 stray write vector", d, 8'h0F);
    rd(4'h5, d); chk("R10 stray write status", d, 8'h80);
    wr(4'h5, 8'h80); step();
    chk("R1 re-enabled", {7'd0, irq_n}, 8'h00);
    clr_port_read = 1; step(); clr_port_read = 0; step();
    chk("R1 cleared cause", {7'd0, irq_n}, 8'h01);

    // R9 vector write and acknowledge priority
    wr(4'hC, 8'h5A);
    rd(4'hC, d); chk("R9 vector read", d, 8'h5A);
    iack_n = 0; cpu_rd = 1; cpu_addr = 4'h5;
    #1 chk("R9 ack priority", cpu_rdata, 8'h5A);
    iack_n = 1; cpu_rd = 0;
    #1 chk("R9 idle bus", cpu_rdata, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule